// File: doc/BRIEF.md
# Serial Stereo Audio Capture and 32 kHz Resampler

This block takes the three-wire serial stream that a sound generator sends to its stereo DAC and turns it into 16-bit signed stereo samples at 32 kHz, ready for an audio sample packet builder that runs on the 27 MHz pixel clock. The serial lines are a bit clock, a data line and two word-select lines, one that closes a left word and one that closes a right word. None of them is related to the pixel clock. All four lines are brought into the pixel domain through two-flop synchronisers and processed there using edge detection. The serial clock must therefore be well below a quarter of the pixel clock, which the source's roughly 55.6 kHz frame rate easily allows.

A 15-bit capture register receives the data least significant bit first. The falling edge of each select line copies the register into that channel's holding register. Each left word marks one input frame. A phase accumulator decides on which frames a 32 kHz output sample is emitted, using nearest-sample decimation. The emitted pair is re-centred from offset binary to two's complement and then attenuated by an arithmetic right shift. It comes with a one-cycle strobe and a running sample counter that the clock-regeneration logic can use.

Top module: `audcap_resampler`

## Requirements
- R1: On every rising edge of `ser_bclk`, the capture register shifts right by one place and `ser_data` enters bit 14. Fifteen bits sent least significant bit first therefore leave the word `w[14:0]` in the register.
- R2: A falling edge on `ser_sel_left` copies the capture register into the left holding register and counts one input frame.
- R3: A falling edge on `ser_sel_right` copies the capture register into the right holding register independently of the left channel, and does not count a frame.
- R4: A held word `w` (offset binary, 0..32767) is output as the signed 16-bit value (w − 16384) × 2.
- R5: The output value is arithmetically shifted right by `atten` (0..7) bits, so the sign is kept and low bits are dropped.
- R6: After n input frames since reset, exactly floor(n × 32000 / 55556) output strobes have occurred. Each strobe carries the most recently latched left and right words.
- R7: `smp_valid` is high for exactly one cycle per output sample. `smp_left` and `smp_right` change only in a cycle where `smp_valid` is high.
- R8: `smp_count` increases by one with each strobe, wraps at its width, and changes at no other time.
- R9: During and right after a synchronous reset, `smp_left`, `smp_right`, `smp_valid` and `smp_count` are all zero, and the decimation phase restarts at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_bclk | input | 1 | Serial bit clock, asynchronous |
| ser_sel_left | input | 1 | Left word select; falling edge latches left |
| ser_sel_right | input | 1 | Right word select; falling edge latches right |
| ser_data | input | 1 | Serial data, LSB first |
| atten | input | 3 | Attenuation shift count |
| smp_left | output | 16 | Signed left output sample |
| smp_right | output | 16 | Signed right output sample |
| smp_valid | output | 1 | One-cycle strobe per 32 kHz sample |
| smp_count | output | 16 | Running count of emitted samples |

## Verification
A select-line edge reaches the holding registers on the third pixel clock after it is driven: two synchroniser flops, then the edge-detect register. The output pair and strobe follow one cycle after that, so the strobe comes four to five cycles after a left falling edge. The bench holds each serial level for four clock cycles and waits ten cycles after every left word before it checks the strobe count and the counter, so each result has settled by then. A monitor on the falling clock edge compares every strobed pair with the words of the frame just sent. It also checks that the strobe never lasts two cycles and that the outputs do not move between strobes.

// File: rtl/audcap_pkg.sv
package audcap_pkg;
  parameter int AUD_OUT_W = 16;
  typedef logic signed [AUD_OUT_W-1:0] aud_sample_t;
  typedef struct packed {
    aud_sample_t left;
    aud_sample_t right;
  } aud_pair_t;
  localparam int CH_LEFT  = 0;
  localparam int CH_RIGHT = 1;
  localparam int CH_NUM   = 2;
endpackage

// File: rtl/audcap_sync.sv
module audcap_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '0;
      else     chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/audcap_deser.sv
module audcap_deser
  import audcap_pkg::*;
#(
  parameter int CAP_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bclk_s,
  input  logic [CH_NUM-1:0] sel_s,
  input  logic             data_s,
  output logic [CAP_W-1:0] raw [CH_NUM],
  output logic             frame_evt
);
  logic             bclk_q;
  logic [CH_NUM-1:0] sel_q;
  logic [CAP_W-1:0] shreg;
  logic             bclk_rise;
  logic [CH_NUM-1:0] sel_fall;

  assign bclk_rise = bclk_s & ~bclk_q;
  assign sel_fall  = sel_q & ~sel_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      bclk_q    <= 1'b0;
      sel_q     <= '0;
      shreg     <= '0;
      frame_evt <= 1'b0;
    end else begin
      bclk_q    <= bclk_s;
      sel_q     <= sel_s;
      frame_evt <= sel_fall[CH_LEFT];
      if (bclk_rise) shreg <= {data_s, shreg[CAP_W-1:1]};
    end
  end

  for (genvar c = 0; c < CH_NUM; c++) begin : g_chan
    always_ff @(posedge clk) begin
      if (rst)              raw[c] <= '0;
      else if (sel_fall[c]) raw[c] <= shreg;
    end
  end
endmodule

// File: rtl/audcap_decim.sv
module audcap_decim
  import audcap_pkg::*;
#(
  parameter int CAP_W    = 15,
  parameter int ATT_W    = 3,
  parameter int IN_RATE  = 55556,
  parameter int OUT_RATE = 32000,
  parameter int CNT_W    = 16,
  localparam int ACC_W   = $clog2(IN_RATE + OUT_RATE),
  localparam int PAD     = AUD_OUT_W - CAP_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_evt,
  input  logic [CAP_W-1:0] raw_l,
  input  logic [CAP_W-1:0] raw_r,
  input  logic [ATT_W-1:0] atten,
  output aud_pair_t        pair,
  output logic             valid,
  output logic [CNT_W-1:0] count,
  output logic [ACC_W-1:0] phase
);
  logic [ACC_W-1:0] sum;
  logic             emit;

  function automatic aud_sample_t recentre(input logic [CAP_W-1:0] w,
                                           input logic [ATT_W-1:0] sh);
    aud_sample_t c;
    c = {~w[CAP_W-1], w[CAP_W-2:0], {PAD{1'b0}}};
    return c >>> sh;
  endfunction

  assign sum  = phase + ACC_W'(OUT_RATE);
  assign emit = frame_evt && (sum >= ACC_W'(IN_RATE));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
      pair  <= '0;
      valid <= 1'b0;
      count <= '0;
    end else begin
      valid <= emit;
      if (frame_evt) phase <= emit ? sum - ACC_W'(IN_RATE) : sum;
      if (emit) begin
        pair.left  <= recentre(raw_l, atten);
        pair.right <= recentre(raw_r, atten);
        count      <= count + 1'b1;
      end
    end
  end
endmodule

// File: rtl/audcap_resampler.sv
module audcap_resampler
  import audcap_pkg::*;
#(
  parameter int CAP_W       = 15,
  parameter int ATT_W       = 3,
  parameter int IN_RATE     = 55556,
  parameter int OUT_RATE    = 32000,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  localparam int ACC_W      = $clog2(IN_RATE + OUT_RATE)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        ser_bclk,
  input  logic                        ser_sel_left,
  input  logic                        ser_sel_right,
  input  logic                        ser_data,
  input  logic [ATT_W-1:0]            atten,
  output logic signed [AUD_OUT_W-1:0] smp_left,
  output logic signed [AUD_OUT_W-1:0] smp_right,
  output logic                        smp_valid,
  output logic [CNT_W-1:0]            smp_count
);
  logic [3:0]       sync_in, sync_out;
  logic [CAP_W-1:0] raw [CH_NUM];
  logic             frame_evt;
  aud_pair_t        pair;
  logic [ACC_W-1:0] phase;

  assign sync_in = {ser_data, ser_sel_right, ser_sel_left, ser_bclk};

  audcap_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(sync_in), .q(sync_out)
  );

  audcap_deser #(.CAP_W(CAP_W)) u_deser (
    .clk(clk), .rst(rst), .bclk_s(sync_out[0]), .sel_s(sync_out[2:1]),
    .data_s(sync_out[3]), .raw(raw), .frame_evt(frame_evt)
  );

  audcap_decim #(.CAP_W(CAP_W), .ATT_W(ATT_W), .IN_RATE(IN_RATE),
                 .OUT_RATE(OUT_RATE), .CNT_W(CNT_W)) u_decim (
    .clk(clk), .rst(rst), .frame_evt(frame_evt), .raw_l(raw[CH_LEFT]),
    .raw_r(raw[CH_RIGHT]), .atten(atten), .pair(pair), .valid(smp_valid),
    .count(smp_count), .phase(phase)
  );

  assign smp_left  = pair.left;
  assign smp_right = pair.right;
endmodule

// File: rtl/audcap_chk.sv
module audcap_chk #(
  parameter int OUT_W   = 16,
  parameter int CNT_W   = 16,
  parameter int ACC_W   = 17,
  parameter int IN_RATE = 55556
) (
  input logic             clk,
  input logic             rst,
  input logic             valid,
  input logic [CNT_W-1:0] count,
  input logic [OUT_W-1:0] left,
  input logic [OUT_W-1:0] right,
  input logic [ACC_W-1:0] phase
);
  // R7: strobe lasts one cycle
  a_r7_single_strobe: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);
  // R7: outputs hold between strobes
  a_r7_hold_left: assert property (@(posedge clk) disable iff (rst)
    !valid |-> $stable(left));
  a_r7_hold_right: assert property (@(posedge clk) disable iff (rst)
    !valid |-> $stable(right));
  // R8: counter moves only with a strobe, by one
  a_r8_count_step: assert property (@(posedge clk) disable iff (rst)
    (count != $past(count)) |-> (valid && count == $past(count) + 1'b1));
  // R6: decimation phase stays below one input period
  a_r6_phase_bounded: assert property (@(posedge clk) disable iff (rst)
    phase < ACC_W'(IN_RATE));
endmodule

bind audcap_resampler audcap_chk #(
  .OUT_W(audcap_pkg::AUD_OUT_W), .CNT_W(CNT_W), .ACC_W(ACC_W), .IN_RATE(IN_RATE)
) u_chk (
  .clk(clk), .rst(rst), .valid(smp_valid), .count(smp_count),
  .left(smp_left), .right(smp_right), .phase(phase)
);

// File: tb/test_audcap_resampler.sv
module test_audcap_resampler;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bclk = 1'b0, sel_l = 1'b0, sel_r = 1'b0, sdat = 1'b0;
  logic [2:0] atten = 3'd0;
  logic signed [15:0] o_l, o_r;
  logic o_v;
  logic [15:0] o_cnt;

  int tests = 0, fails = 0;
  int frames = 0, seen = 0;
  int exp_l = 0, exp_r = 0;
  logic prev_v = 1'b0;
  logic signed [15:0] prev_l = '0, prev_r = '0;

  always #2.5 clk = ~clk;

  audcap_resampler i_audcap_resampler (
    .clk(clk), .rst(rst), .ser_bclk(bclk), .ser_sel_left(sel_l),
    .ser_sel_right(sel_r), .ser_data(sdat), .atten(atten),
    .smp_left(o_l), .smp_right(o_r), .smp_valid(o_v), .smp_count(o_cnt)
  );

  function automatic int model(input logic [14:0] w, input logic [2:0] sh);
    int v;
    v = (int'(w) - 16384) * 2;
    return v >>> sh;
  endfunction

  function automatic int emits(input int n);
    return (n * 32000) / 55556;
  endfunction

  task automatic check(input string tag, input int act, input int expv);
    tests++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_word(input logic [14:0] w, input bit left);
    if (left) sel_l = 1'b1; else sel_r = 1'b1;
    for (int i = 0; i < 15; i++) begin
      sdat = w[i];
      ticks(4);
      bclk = 1'b1;
      ticks(4);
      bclk = 1'b0;
    end
    ticks(4);
    if (left) sel_l = 1'b0; else sel_r = 1'b0;
  endtask

  // right word first, then left word that closes the frame
  task automatic send_frame(input logic [14:0] l, input logic [14:0] r,
                            input logic [2:0] sh);
    atten = sh;
    exp_l = model(l, sh);
    exp_r = model(r, sh);
    send_word(r, 1'b0);
    ticks(4);
    send_word(l, 1'b1);
    frames++;
    ticks(10);
    check("R6 strobe total", seen, emits(frames));
    check("R8 sample counter", int'(o_cnt), emits(frames));
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (o_v) begin
        seen++;
        check("R1 R2 R4 R5 left value", int'(o_l), exp_l);
        check("R3 R4 R5 right value", int'(o_r), exp_r);
        if (prev_v) check("R7 strobe width", 2, 1);
      end else begin
        if (o_l != prev_l) check("R7 left moved without strobe", int'(o_l), int'(prev_l));
        if (o_r != prev_r) check("R7 right moved without strobe", int'(o_r), int'(prev_r));
      end
    end
    prev_v = o_v;
    prev_l = o_l;
    prev_r = o_r;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h5eed_1234);
    ticks(5);
    check("R9 reset left", int'(o_l), 0);
    check("R9 reset right", int'(o_r), 0);
    check("R9 reset valid", int'(o_v), 0);
    check("R9 reset count", int'(o_cnt), 0);
    rst = 1'b0;
    ticks(3);
    // R6: first frame gives no sample, second gives one
    send_frame(15'h0000, 15'h7fff, 3'd0);
    check("R6 no strobe after first frame", seen, 0);
    send_frame(15'h0000, 15'h7fff, 3'd0);
    check("R6 one strobe after second frame", seen, 1);
    // R5: sign kept under attenuation
    send_frame(15'h0000, 15'h7fff, 3'd1);
    send_frame(15'h0001, 15'h4000, 3'd2);
    send_frame(15'h3fff, 15'h4001, 3'd7);
    // R3: a right word alone closes no frame
    send_word(15'h1234, 1'b0);
    ticks(10);
    check("R3 right-only word emits nothing", seen, emits(frames));
    for (int k = 0; k < 50; k++) begin
      send_frame(15'($urandom), 15'($urandom), 3'($urandom % 8));
    end
    // R9: reset restarts phase and counter
    rst = 1'b1;
    ticks(3);
    check("R9 count after reset", int'(o_cnt), 0);
    rst = 1'b0;
    frames = 0;
    seen = 0;
    ticks(3);
    send_frame(15'h2222, 15'h5555, 3'd0);
    check("R9 phase restarted", seen, 0);
    send_frame(15'h2222, 15'h5555, 3'd0);
    check("R9 phase restarted second", seen, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule